// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block is the serial end of an audio playback path. It runs from the master clock and divides that clock down to a bit clock and a word select, which it drives as the bus master. It pulls one 32-bit sample word per channel slot from an upstream FIFO through a valid/ready handshake. Each word is sent MSB first in the standard I2S arrangement, with word select low for the left slot and high for the right slot. The data line lags each word-select change by one bit clock.

Software, through a register block that is not part of this design, sets a divider value and a per-channel resolution, then raises the transmit enable. The block captures both fields and sends one frame of silence. After that it sends queued words, left then right. When the FIFO runs dry it fills the slot with zeros. When the enable drops it completes the frame in progress and parks the bus in a quiet state. A master clock of 256 times the sample rate gives 32-bit stereo with a divider value of 0 and 16-bit stereo with a divider value of 2.

Top module: `i2s_ser_tx`

## Requirements
- R1: After reset, bitClk, wordSel, serData and fifoReady are all 0.
- R2: While transmitting, bitClk has a period of 2*(ratioSel+2) master clock cycles. It is high for ratioSel+2 cycles and low for ratioSel+2 cycles.
- R3: serData and wordSel change only on the master clock edge where bitClk falls.
- R4: After the enable rises from the quiet state, the first frame carries zeros in both slots, left first, and no FIFO word is taken for it.
- R5: Slots alternate left (wordSel 0) and right (wordSel 1), one FIFO word per slot. Each word is sent MSB first, and its first bit appears one bit clock after the word-select change.
- R6: A slot is resSel bit clocks long and carries the low resSel bits of the word. A resSel of 0 or above 32 is treated as 32.
- R7: fifoReady is high for exactly one master clock cycle at each data slot start, and a word is taken only when fifoValid and fifoReady are both high. If fifoValid is low at that point, the slot carries zeros and nothing is taken.
- R8: When txEnable is low at the end of a right slot, the block sends that slot's last bit, then stops. bitClk, wordSel and serData are then held at 0 and no word is taken while it stays quiet.
- R9: ratioSel and resSel are captured when transmission starts, and changes to them during transmission have no effect.
- R10: A new transmission started after a stop begins again with a frame of zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset |
| txEnable | input | 1 | Transmit enable |
| ratioSel | input | 8 | Divider value; bit clock = mclk / (2*(ratioSel+2)) |
| resSel | input | 6 | Bits per channel slot |
| fifoData | input | 32 | Sample word at the FIFO head |
| fifoValid | input | 1 | FIFO head word present |
| fifoReady | output | 1 | Take the FIFO head word this cycle |
| bitClk | output | 1 | Serial bit clock |
| wordSel | output | 1 | Channel select, 0 left, 1 right |
| serData | output | 1 | Serial data, MSB first |

## Verification
The assertions check on every cycle that the bit clock never toggles on two consecutive master clocks. They also check that the data and word-select lines move only where the bit clock falls, that the ready pulse lasts a single cycle, and that the bit clock stays low while the block is quiet with the enable low. The bench scenarios are needed for the content of the stream. A bench receiver rebuilds every slot from the bit clock, so the scenarios can show the leading silent frame, channel order, MSB-first order, truncation to the resolution, zero-filled slots on an empty FIFO, a clean stop at the frame boundary, restart behaviour, and the exact bit clock period when the divider value is changed mid-stream.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  // Strobes from the control FSM to the shift datapath, valid for one mclk.
  typedef struct packed {
    logic shift;   // bit clock falls on this edge: advance the data line
    logic load;    // a new slot starts: reload the shift register
    logic fill;    // the new slot takes the FIFO head word (zeros otherwise)
    logic wsNext;  // channel of the slot being started
    logic clear;   // end of drain: park every output low
  } strobe_t;

endpackage

// File: rtl/i2s_ser_ctrl.sv
module i2s_ser_ctrl
  import i2s_ser_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic [RES_W-1:0]   resSel,
  output logic               bitClk,
  output logic               fifoReady,
  output logic [RES_W-1:0]   slotLen,
  output strobe_t            st
);

  localparam int DIV_W = RATIO_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_t;

  state_t           stateR;
  logic             bitClkR;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLim;
  logic [RES_W-1:0] resL;
  logic [RES_W-1:0] bitCnt;
  logic             rightR;
  logic             primeR;

  logic             startTick;
  logic             halfDone;
  logic             fallTick;
  logic             lastBit;
  logic             boundary;
  logic             stopNow;
  logic [RES_W-1:0] resClamped;

  assign resClamped = (resSel == '0 || resSel > RES_W'(WORD_W)) ? RES_W'(WORD_W) : resSel;

  assign startTick = (stateR == ST_IDLE) && txEnable;
  assign halfDone  = (stateR != ST_IDLE) && (divCnt == halfLim);
  assign fallTick  = halfDone && bitClkR;
  assign lastBit   = (bitCnt == resL - RES_W'(1));
  assign boundary  = (stateR == ST_RUN) && fallTick && lastBit;
  assign stopNow   = boundary && rightR && !txEnable;

  always_comb begin
    st.shift  = startTick || fallTick;
    st.load   = startTick || boundary;
    st.fill   = boundary && !primeR && !stopNow;
    st.wsNext = boundary ? ~rightR : 1'b0;
    st.clear  = (stateR == ST_DRAIN) && fallTick;
  end

  assign fifoReady = st.fill;
  assign bitClk    = bitClkR;
  assign slotLen   = resL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR  <= ST_IDLE;
      bitClkR <= 1'b0;
      divCnt  <= '0;
      halfLim <= '0;
      resL    <= RES_W'(WORD_W);
      bitCnt  <= '0;
      rightR  <= 1'b0;
      primeR  <= 1'b0;
    end else begin
      unique case (stateR)
        ST_IDLE: begin
          if (txEnable) begin
            stateR  <= ST_RUN;
            bitClkR <= 1'b0;
            divCnt  <= '0;
            halfLim <= DIV_W'(ratioSel) + DIV_W'(1);
            resL    <= resClamped;
            bitCnt  <= '0;
            rightR  <= 1'b0;
            primeR  <= 1'b1;
          end
        end
        ST_RUN, ST_DRAIN: begin
          if (halfDone) begin
            divCnt  <= '0;
            bitClkR <= ~bitClkR;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
          if (stateR == ST_RUN && fallTick) begin
            if (lastBit) begin
              bitCnt <= '0;
              rightR <= ~rightR;
              primeR <= 1'b0;
              if (stopNow) stateR <= ST_DRAIN;
            end else begin
              bitCnt <= bitCnt + RES_W'(1);
            end
          end
          if (stateR == ST_DRAIN && fallTick) begin
            stateR <= ST_IDLE;
            divCnt <= '0;
          end
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitClkR) |=> $stable(bitClkR));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoReady |=> !fifoReady);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_IDLE && !txEnable) |=> !bitClkR);

endmodule

// File: rtl/i2s_ser_dp.sv
module i2s_ser_dp
  import i2s_ser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [RES_W-1:0]  slotLen,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              fifoValid,
  output logic              wordSel,
  output logic              serData
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] alignedWord;
  logic [WORD_W-1:0] loadWord;
  logic [RES_W-1:0]  padBits;

  // Move the low slotLen bits of the word to the top so they leave MSB first.
  assign padBits     = RES_W'(WORD_W) - slotLen;
  assign alignedWord = fifoData << padBits;
  assign loadWord    = (st.fill && fifoValid) ? alignedWord : '0;

  // The top bit is moved to the line on every falling bit clock, one bit
  // behind the slot boundary: the edge that reloads the register still
  // sends the previous slot's last bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serData  <= 1'b0;
      wordSel  <= 1'b0;
    end else if (st.clear) begin
      shiftReg <= '0;
      serData  <= 1'b0;
      wordSel  <= 1'b0;
    end else if (st.shift) begin
      serData  <= shiftReg[WORD_W-1];
      shiftReg <= st.load ? loadWord : (shiftReg << 1);
      if (st.load) wordSel <= st.wsNext;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (shiftReg == '0));

endmodule

// File: rtl/i2s_ser_tx.sv
module i2s_ser_tx
  import i2s_ser_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               mclk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic [RES_W-1:0]   resSel,
  input  logic [WORD_W-1:0]  fifoData,
  input  logic               fifoValid,
  output logic               fifoReady,
  output logic               bitClk,
  output logic               wordSel,
  output logic               serData
);

  strobe_t          st;
  logic [RES_W-1:0] slotLen;

  i2s_ser_ctrl #(.WORD_W(WORD_W), .RATIO_W(RATIO_W), .RES_W(RES_W)) uCtrl (
    .clk       (mclk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .ratioSel  (ratioSel),
    .resSel    (resSel),
    .bitClk    (bitClk),
    .fifoReady (fifoReady),
    .slotLen   (slotLen),
    .st        (st)
  );

  i2s_ser_dp #(.WORD_W(WORD_W), .RES_W(RES_W)) uDp (
    .clk       (mclk),
    .rstN      (rstN),
    .st        (st),
    .slotLen   (slotLen),
    .fifoData  (fifoData),
    .fifoValid (fifoValid),
    .wordSel   (wordSel),
    .serData   (serData)
  );

  // R3
  data_edge_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !$stable(serData) |-> $fell(bitClk));

  // R3
  ws_edge_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !$stable(wordSel) |-> $fell(bitClk));

endmodule

// File: tb/sim_i2s_ser_tx.sv
`timescale 1ns/1ps
module sim_i2s_ser_tx;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic [7:0]  ratioSel = 8'd0;
  logic [5:0]  resSel = 6'd32;
  logic [31:0] fifoData;
  logic        fifoValid, fifoReady, bitClk, wordSel, serData;

  logic [31:0] fifoMem [0:63];
  int wrCnt = 0;
  int rdPtr = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign fifoValid = rdPtr < wrCnt;
  assign fifoData  = fifoMem[rdPtr[5:0]];

  always @(posedge clk) if (fifoValid && fifoReady) rdPtr <= rdPtr + 1;

  i2s_ser_tx u0 (
    .mclk(clk), .rstN(rstN), .txEnable(txEnable), .ratioSel(ratioSel),
    .resSel(resSel), .fifoData(fifoData), .fifoValid(fifoValid),
    .fifoReady(fifoReady), .bitClk(bitClk), .wordSel(wordSel), .serData(serData)
  );

  // Receiver model: samples on each rising bit clock, seen at the mclk falling edge.
  int          cyc = 0;
  logic        prevBclk = 1'b0, prevWs = 1'b0, prevSd = 1'b0, rxWs = 1'b0;
  logic [31:0] acc = '0;
  logic [31:0] rxMask = '1;
  logic [31:0] rxWord [0:31];
  logic        rxCh [0:31];
  int rxN = 0, lastRise = -1, minP = 0, maxP = 0, edgeViol = 0, quiet = 0;
  logic [31:0] expW [0:7];

  always @(negedge clk) begin
    int p;
    cyc++;
    if (bitClk && !prevBclk) begin
      quiet = 0;
      if (lastRise >= 0) begin
        p = cyc - lastRise;
        if (minP == 0 || p < minP) minP = p;
        if (p > maxP) maxP = p;
      end
      lastRise = cyc;
      if (wordSel != rxWs) begin
        if (rxN < 32) begin
          rxWord[rxN] = {acc[30:0], serData} & rxMask;
          rxCh[rxN]   = rxWs;
        end
        rxN++;
        acc = '0;
      end else begin
        acc = {acc[30:0], serData};
      end
      rxWs = wordSel;
    end else begin
      quiet++;
    end
    if ((serData !== prevSd || wordSel !== prevWs) && !(prevBclk && !bitClk)) edgeViol++;
    prevBclk = bitClk;
    prevSd   = serData;
    prevWs   = wordSel;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fifoMem[wrCnt[5:0]] = w;
    wrCnt++;
  endtask

  task automatic clearRx(input logic [31:0] mask);
    rxN = 0; acc = '0; lastRise = -1; minP = 0; maxP = 0; rxMask = mask;
  endtask

  // Start a stream, wait for nPop words to be taken, drop the enable, wait for quiet.
  task automatic play(input int ratio, input int res, input int nPop, input logic [31:0] mask,
                      input int altAfter, input int altRatio, input int altRes);
    int base = rdPtr;
    int lim;
    clearRx(mask);
    ratioSel = ratio[7:0];
    resSel   = res[5:0];
    @(negedge clk);
    txEnable = 1'b1;
    if (altAfter > 0) begin
      repeat (altAfter) @(negedge clk);
      ratioSel = altRatio[7:0];
      resSel   = altRes[5:0];
    end
    while (rdPtr - base < nPop) @(negedge clk);
    txEnable = 1'b0;
    lim = 4 * (ratio + 2) + 10;
    quiet = 0;
    while (quiet < lim) @(negedge clk);
  endtask

  task automatic checkRx(input string tag, input int n);
    chk(tag, "slot count", rxN, n);
    for (int i = 0; i < n && i < 32; i++) begin
      chk(tag, "slot word", rxWord[i], expW[i]);
      chk(tag, "slot channel", {31'b0, rxCh[i]}, i % 2);
    end
  endtask

  task automatic checkPeriod(input string tag, input int ratio);
    chk(tag, "min bit clock period", minP, 2 * (ratio + 2));
    chk(tag, "max bit clock period", maxP, 2 * (ratio + 2));
  endtask

  task automatic checkQuiet(input string tag);
    chk(tag, "bitClk parked", {31'b0, bitClk}, 0);
    chk(tag, "wordSel parked", {31'b0, wordSel}, 0);
    chk(tag, "serData parked", {31'b0, serData}, 0);
  endtask

  task automatic testReset();
    // R1
    checkQuiet("R1");
    chk("R1", "fifoReady after reset", {31'b0, fifoReady}, 0);
  endtask

  task automatic testStereo32();
    int base = rdPtr;
    // R2 R4 R5: 32-bit slots, divider 0, four words
    push(32'h0123_4567); push(32'h89AB_CDEF); push(32'hA5A5_0F0F); push(32'h5A5A_F0F0);
    expW[0] = 0; expW[1] = 0;
    expW[2] = 32'h0123_4567; expW[3] = 32'h89AB_CDEF; expW[4] = 32'hA5A5_0F0F; expW[5] = 32'h5A5A_F0F0;
    play(0, 32, 4, 32'hFFFF_FFFF, 0, 0, 0);
    checkRx("R4 R5", 6);
    checkPeriod("R2", 0);
    chk("R5", "words taken", rdPtr - base, 4);
  endtask

  task automatic testStereo16();
    // R6 R2: 16-bit slots, divider 2, upper bits must be dropped
    push(32'hDEAD_1234); push(32'hBEEF_8001); push(32'h0000_FFFF); push(32'h1234_0000);
    expW[0] = 0; expW[1] = 0;
    expW[2] = 32'h1234; expW[3] = 32'h8001; expW[4] = 32'hFFFF; expW[5] = 32'h0000;
    play(2, 16, 4, 32'h0000_FFFF, 0, 0, 0);
    checkRx("R6", 6);
    checkPeriod("R2", 2);
  endtask

  task automatic testUnderrunStop();
    int base = rdPtr;
    int held;
    // R7: three words, so the right slot of the second data frame finds the FIFO empty
    push(32'h0000_00C3); push(32'h0000_7001); push(32'h0000_8E00);
    expW[0] = 0; expW[1] = 0;
    expW[2] = 32'h00C3; expW[3] = 32'h7001; expW[4] = 32'h8E00; expW[5] = 0;
    play(0, 16, 3, 32'h0000_FFFF, 0, 0, 0);
    checkRx("R7", 6);
    chk("R7", "words taken with empty FIFO", rdPtr - base, 3);
    // R8: quiet after the frame ends; a newly queued word is left alone
    checkQuiet("R8");
    held = rdPtr;
    push(32'hC0FF_EE01);
    quiet = 0;
    repeat (200) @(negedge clk);
    chk("R8", "no word taken while quiet", rdPtr, held);
    chk("R8", "no bit clock while quiet", (quiet >= 200) ? 1 : 0, 1);
    checkQuiet("R8");
  endtask

  task automatic testLatchedFields();
    // R9 R6: resolution 0 means 32; divider and resolution change mid-stream
    push(32'h8000_0001);
    expW[0] = 0; expW[1] = 0; expW[2] = 32'hC0FF_EE01; expW[3] = 32'h8000_0001;
    play(5, 0, 2, 32'hFFFF_FFFF, 30, 1, 16);
    checkRx("R9", 4);
    checkPeriod("R9", 5);
  endtask

  task automatic testRestart();
    // R10: a second start again leads with a silent frame
    push(32'h0000_ABCD); push(32'h0000_4321);
    expW[0] = 0; expW[1] = 0; expW[2] = 32'hABCD; expW[3] = 32'h4321;
    play(0, 16, 2, 32'h0000_FFFF, 0, 0, 0);
    checkRx("R10", 4);
    checkQuiet("R10");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) fifoMem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStereo32();
    testStereo16();
    testUnderrunStop();
    testLatchedFields();
    testRestart();
    // R3
    chk("R3", "line changes away from falling bit clock", edgeViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule